// File: doc/BRIEF.md
# SDRAM Bring-up and Power-down Sequencer

This block owns the life cycle of an SDRAM device outside normal data traffic. After an asynchronous active-low reset it keeps the command pins at NOP. It waits until software writes the first configuration register, and that write starts the power-up sequence. The sequence is a long NOP wait, a precharge of all banks, a run of auto-refresh commands and a mode-register load. A bit in the same write selects whether the run has eight auto-refreshes or two. When the sequence completes, a level output reports that the memory is ready.

After bring-up, an external burst engine moves the data. This block gates that engine through a grant output. Periodic refresh ticks from a timer are counted here. To service a tick, the block withdraws the grant, waits for the engine to go idle and issues an auto-refresh. A second configuration bit asks for power-down. The block drains the engine and drops clock enable. Any refresh tick that arrives while the device sleeps is held and serviced after wake-up, before the engine is granted again.

Every output is registered on the rising clock edge.

Top module: `sdram_bringup_ctrl`

## Requirements
- R1: Until the first write to register 0 (write strobe `cfg_we[0]`), the command pins stay at NOP. Register 0 writes made after the start do not restart the power-up sequence and do not lower `init_done`.
- R2: The command pins show precharge exactly INIT_WAIT+1 cycles after the starting write edge, with `mem_addr[10]` high. The first auto-refresh follows T_RP+1 cycles after the precharge. Each later auto-refresh, and then the mode load, follows T_RFC+1 cycles after the previous command. The mode load drives MODE_WORD on `mem_addr`.
- R3: Register 0 bit 0 as written at the starting write selects the auto-refresh count of the power-up sequence: 1 gives eight, 0 gives two.
- R4: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode load = 0000. No other code is ever driven.
- R5: `init_done` rises T_MRD+1 cycles after the mode-load command. It then stays high until reset, and reset clears it.
- R6: Setting register 0 bit 1 requests power-down. The grant falls first. `mem_cke` goes low only after `engine_busy` is low, and it stays high for as long as the engine stays busy.
- R7: Clearing register 0 bit 1 raises `mem_cke`. With no refresh pending, the grant returns exactly T_XP cycles after `mem_cke` rises.
- R8: Refresh ticks that arrive during power-down issue no command while `mem_cke` is low. After wake-up, one auto-refresh per tick (saturating at 2^PEND_W-1) is issued before the grant returns.
- R9: A refresh tick in normal operation drops the grant, waits for `engine_busy` to go low, issues one auto-refresh and then restores the grant.
- R10: Refresh ticks before `init_done` are discarded. They add no refresh after bring-up.
- R11: `cfg_rdata` is registered and follows a one-hot `cfg_re`. Bit 0 reads register 0, which holds the refresh select in bit 0 and the power-down bit in bit 1, with zero above. Bit 1 reads the 32-bit register 1. Bit 2, and any select that is not one-hot, reads zero.
- R12: During reset the pins show NOP, `mem_cke` high, grant low, `init_done` low and `cfg_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 2 | Write strobes for registers 0 and 1 |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_re | input | 3 | One-hot read select for registers 0 to 2 |
| cfg_rdata | output | 32 | Registered configuration read data |
| ref_tick | input | 1 | One-cycle refresh request from the refresh timer |
| engine_busy | input | 1 | The external burst engine is mid-transfer |
| engine_grant | output | 1 | The burst engine may use the memory |
| init_done | output | 1 | Level: the power-up sequence has finished |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | SDRAM chip select, active low |
| mem_ras_n | output | 1 | SDRAM row strobe, active low |
| mem_cas_n | output | 1 | SDRAM column strobe, active low |
| mem_we_n | output | 1 | SDRAM write enable, active low |
| mem_addr | output | 12 | SDRAM address bus |
| mem_ba | output | 2 | SDRAM bank select |

## Verification
The hardest state to reach is a refresh backlog that builds up while the device sleeps and must drain before the grant comes back. The bench first holds the engine busy through a power-down request, to show that clock enable stays high. It then releases the engine and pulses two ticks while clock enable is low. It clears the power-down bit and uses the logged command cycles to place both refreshes between the clock-enable rise and the grant rise. It also exercises the exact wake-up delay once with no backlog.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes the {cs_n, ras_n, cas_n, we_n} pin order for command codes.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        IS_IDLE, IS_WAIT, IS_PRE, IS_PRE_GAP, IS_REF,
        IS_REF_GAP, IS_LMR, IS_LMR_GAP, IS_DONE
    } init_st_e;

    typedef enum logic [2:0] {
        PS_OFF, PS_RUN, PS_DRAIN, PS_REF, PS_REF_GAP, PS_DOWN, PS_EXIT
    } pm_st_e;

endpackage

// File: rtl/sbc_cfg_regs.sv
// Configuration register file: register 0 (refresh select, power-down bit),
// register 1 (32-bit word), register 2 (reads zero).
// Assumes one-hot read selects; any other select pattern returns zero.
module sbc_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int NREG   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NREG-1:0]   cfg_re,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              pd_want
);
    logic              ref8_q;
    logic              pd_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] view [NREG];
    logic [DATA_W-1:0] rd_next;

    // Capture register writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref8_q <= 1'b0;
            pd_q   <= 1'b0;
            word_q <= '0;
        end else begin
            if (cfg_we[0]) begin
                ref8_q <= cfg_wdata[0];
                pd_q   <= cfg_wdata[1];
            end
            if (cfg_we[1]) begin
                word_q <= cfg_wdata;
            end
        end
    end

    // Present each register as a full-width read view.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_view
            if (g == 0) begin : g_r0
                assign view[g] = {{(DATA_W-2){1'b0}}, pd_q, ref8_q};
            end else if (g == 1) begin : g_r1
                assign view[g] = word_q;
            end else begin : g_rz
                assign view[g] = '0;
            end
        end
    endgenerate

    // Select the read view when exactly one enable is set.
    always_comb begin
        rd_next = '0;
        if ($onehot(cfg_re)) begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_re[i]) rd_next = view[i];
            end
        end
    end

    // Register the read bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= rd_next;
    end

    assign pd_want = pd_q;
endmodule

// File: rtl/sbc_init_seq.sv
// Power-up sequencer: after the start strobe, it waits INIT_WAIT cycles, then
// issues precharge-all, N auto-refreshes and a mode load, with gaps between.
// Assumes every gap parameter is at least 1 and ADDR_W > 10.
module sbc_init_seq
    import sdram_seq_pkg::*;
#(
    parameter int          INIT_WAIT = 25000,
    parameter int          T_RP      = 2,
    parameter int          T_RFC     = 7,
    parameter int          T_MRD     = 2,
    parameter int          ADDR_W    = 12,
    parameter int unsigned MODE_WORD = 32'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_ref8,
    output sdr_cmd_e          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              started
);
    localparam int CNT_W = $clog2(INIT_WAIT + T_RP + T_RFC + T_MRD + 1);
    localparam int A10   = 10;

    init_st_e         st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       refs_left;
    logic             ref8_lat;

    // Step through the power-up order; cnt times each wait and gap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= IS_IDLE;
            cnt       <= '0;
            refs_left <= '0;
            ref8_lat  <= 1'b0;
        end else begin
            case (st)
                IS_IDLE: if (start) begin
                    st       <= IS_WAIT;
                    cnt      <= CNT_W'(INIT_WAIT - 1);
                    ref8_lat <= start_ref8;
                end
                IS_WAIT: if (cnt == '0) st <= IS_PRE;
                         else           cnt <= cnt - 1'b1;
                IS_PRE: begin
                    st  <= IS_PRE_GAP;
                    cnt <= CNT_W'(T_RP - 1);
                end
                IS_PRE_GAP: if (cnt == '0) begin
                    st        <= IS_REF;
                    refs_left <= ref8_lat ? 3'd7 : 3'd1;
                end else cnt <= cnt - 1'b1;
                IS_REF: begin
                    st  <= IS_REF_GAP;
                    cnt <= CNT_W'(T_RFC - 1);
                end
                IS_REF_GAP: if (cnt == '0) begin
                    if (refs_left == '0) st <= IS_LMR;
                    else begin
                        st        <= IS_REF;
                        refs_left <= refs_left - 1'b1;
                    end
                end else cnt <= cnt - 1'b1;
                IS_LMR: begin
                    st  <= IS_LMR_GAP;
                    cnt <= CNT_W'(T_MRD - 1);
                end
                IS_LMR_GAP: if (cnt == '0) st <= IS_DONE;
                            else           cnt <= cnt - 1'b1;
                default: st <= IS_DONE;
            endcase
        end
    end

    // Decode the state into a command and address.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        case (st)
            IS_PRE: begin
                cmd       = CMD_PRE;
                addr[A10] = 1'b1;
            end
            IS_REF: cmd = CMD_REF;
            IS_LMR: begin
                cmd  = CMD_LMR;
                addr = ADDR_W'(MODE_WORD);
            end
            default: ;
        endcase
    end

    assign done    = (st == IS_DONE);
    assign started = (st != IS_IDLE);
endmodule

// File: rtl/sbc_power_mgr.sv
// Post-bring-up manager: grants the burst engine, collects refresh ticks,
// and handles power-down entry and exit.
// Assumes engine_busy falls within bounded time once the grant is withdrawn.
module sbc_power_mgr
    import sdram_seq_pkg::*;
#(
    parameter int T_RFC  = 7,
    parameter int T_XP   = 3,
    parameter int PEND_W = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     pd_want,
    input  logic     ref_tick,
    input  logic     engine_busy,
    output sdr_cmd_e cmd,
    output logic     cke,
    output logic     grant
);
    localparam int CNT_W = $clog2(T_RFC + T_XP + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    pm_st_e            st;
    logic [CNT_W-1:0]  cnt;
    logic [PEND_W-1:0] pend;
    logic              inc;
    logic              dec;

    assign inc = ref_tick && enable && (pend != PEND_MAX);
    assign dec = (st == PS_REF);

    // Count outstanding refresh ticks; ticks before bring-up are dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend <= '0;
        else if (!enable) pend <= '0;
        else              pend <= pend + PEND_W'(inc) - PEND_W'(dec);
    end

    // Arbitration between the engine, refresh and power-down.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PS_OFF;
            cnt <= '0;
        end else begin
            case (st)
                PS_OFF:   if (enable) st <= PS_RUN;
                PS_RUN:   if (pend != '0 || pd_want) st <= PS_DRAIN;
                PS_DRAIN: if (!engine_busy) begin
                    if (pend != '0)   st <= PS_REF;
                    else if (pd_want) st <= PS_DOWN;
                    else              st <= PS_RUN;
                end
                PS_REF: begin
                    st  <= PS_REF_GAP;
                    cnt <= CNT_W'(T_RFC - 1);
                end
                PS_REF_GAP: if (cnt == '0) st <= PS_RUN;
                            else           cnt <= cnt - 1'b1;
                PS_DOWN: if (!pd_want) begin
                    st  <= PS_EXIT;
                    cnt <= CNT_W'(T_XP - 1);
                end
                PS_EXIT: if (cnt == '0) st <= PS_RUN;
                         else           cnt <= cnt - 1'b1;
                default: st <= PS_OFF;
            endcase
        end
    end

    // Drive the command, clock enable and grant from the state.
    always_comb begin
        cmd   = (st == PS_REF) ? CMD_REF : CMD_NOP;
        cke   = (st != PS_DOWN);
        grant = (st == PS_RUN) && (pend == '0) && !pd_want;
    end
endmodule

// File: rtl/sbc_pin_reg.sv
// Output register stage: every memory-facing pin and status output
// leaves the block from a flop. Assumes the inputs are combinational.
module sbc_pin_reg
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdr_cmd_e          cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cke,
    input  logic              grant,
    input  logic              done,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BA_W-1:0]   mem_ba,
    output logic              mem_cke,
    output logic              engine_grant,
    output logic              init_done
);
    // Register the pins; reset shows NOP with clock enable high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} <= CMD_NOP;
            mem_addr     <= '0;
            mem_ba       <= '0;
            mem_cke      <= 1'b1;
            engine_grant <= 1'b0;
            init_done    <= 1'b0;
        end else begin
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} <= cmd;
            mem_addr     <= addr;
            mem_ba       <= '0;
            mem_cke      <= cke;
            engine_grant <= grant;
            init_done    <= done;
        end
    end
endmodule

// File: rtl/sdram_bringup_ctrl.sv
// Top level: configuration registers, power-up sequencer and power manager
// share one registered pin stage. The sequencer owns the pins until it is
// done; the power manager owns them afterwards.
module sdram_bringup_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int          INIT_WAIT = 25000,
    parameter int          T_RP      = 2,
    parameter int          T_RFC     = 7,
    parameter int          T_MRD     = 2,
    parameter int          T_XP      = 3,
    parameter int          PEND_W    = 3,
    parameter int          ADDR_W    = 12,
    parameter int          BA_W      = 2,
    parameter int          DATA_W    = 32,
    parameter int unsigned MODE_WORD = 32'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [2:0]        cfg_re,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              ref_tick,
    input  logic              engine_busy,
    output logic              engine_grant,
    output logic              init_done,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BA_W-1:0]   mem_ba
);
    logic              pd_want;
    sdr_cmd_e          seq_cmd;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_done;
    logic              seq_started;
    sdr_cmd_e          pm_cmd;
    logic              pm_cke;
    logic              pm_grant;
    sdr_cmd_e          cmd_sel;
    logic [ADDR_W-1:0] addr_sel;

    sbc_cfg_regs #(.DATA_W(DATA_W), .NREG(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .pd_want(pd_want)
    );

    sbc_init_seq #(
        .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .ADDR_W(ADDR_W), .MODE_WORD(MODE_WORD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(cfg_we[0]),
        .start_ref8(cfg_wdata[0]), .cmd(seq_cmd), .addr(seq_addr),
        .done(seq_done), .started(seq_started)
    );

    sbc_power_mgr #(.T_RFC(T_RFC), .T_XP(T_XP), .PEND_W(PEND_W)) u_pm (
        .clk(clk), .rst_n(rst_n), .enable(seq_done), .pd_want(pd_want),
        .ref_tick(ref_tick), .engine_busy(engine_busy), .cmd(pm_cmd),
        .cke(pm_cke), .grant(pm_grant)
    );

    // Hand the pins to whichever unit owns the current phase.
    always_comb begin
        cmd_sel  = seq_done ? pm_cmd : seq_cmd;
        addr_sel = seq_done ? '0 : seq_addr;
    end

    sbc_pin_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_sel), .addr(addr_sel),
        .cke(pm_cke), .grant(pm_grant), .done(seq_done),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ba(mem_ba),
        .mem_cke(mem_cke), .engine_grant(engine_grant), .init_done(init_done)
    );
endmodule

// File: rtl/sbc_checker.sv
// Property checker for the bring-up sequencer, bound to the top module.
module sbc_checker (
    input logic clk,
    input logic rst_n,
    input logic seq_started,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic cke,
    input logic grant,
    input logic done
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    // R1
    idle_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_started |-> pins == 4'b0111);

    // R4
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0111 || pins == 4'b0010 || pins == 4'b0001 || pins == 4'b0000);

    // R2
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins == 4'b0010 |-> a10);

    // R5
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R5
    grant_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> done);

    // R6
    sleep_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !grant);

    // R8
    sleep_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> pins == 4'b0111);

    // R9
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pins == 4'b0111);
endmodule

bind sdram_bringup_ctrl sbc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .seq_started(seq_started),
    .cs_n(mem_cs_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n), .we_n(mem_we_n),
    .a10(mem_addr[10]), .cke(mem_cke), .grant(engine_grant), .done(init_done)
);

// File: tb/sdram_bringup_ctrl_test.sv
module sdram_bringup_ctrl_test;
    localparam int W     = 50;
    localparam int TRP   = 2;
    localparam int TRFC  = 5;
    localparam int TMRD  = 2;
    localparam int TXP   = 4;
    localparam int MODEW = 'h032;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                           C_REF = 4'b0001, C_LMR = 4'b0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cfg_we = 0;
    logic [31:0] cfg_wdata = 0;
    logic [2:0]  cfg_re = 0;
    logic [31:0] cfg_rdata;
    logic        ref_tick = 0, engine_busy = 0;
    logic        engine_grant, init_done, mem_cke;
    logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [11:0] mem_addr;
    logic [1:0]  mem_ba;

    sdram_bringup_ctrl #(.INIT_WAIT(W), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .T_XP(TXP), .MODE_WORD(MODEW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .ref_tick(ref_tick),
        .engine_busy(engine_busy), .engine_grant(engine_grant),
        .init_done(init_done), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_ba(mem_ba));

    always #4 clk = ~clk;

    int n_checks = 0, n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Command log and edge stamps, sampled at the falling edge.
    logic [3:0]  log_cmd [32];
    logic [11:0] log_addr [32];
    int          log_cyc [32];
    int          log_n = 0;
    int          done_cyc = 0, cke_rise = 0, grant_rise = 0;
    logic        p_done = 0, p_cke = 1, p_grant = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_done = 0; p_cke = 1; p_grant = 0;
        end else begin
            if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} != C_NOP && log_n < 32) begin
                log_cmd[log_n]  = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
                log_addr[log_n] = mem_addr;
                log_cyc[log_n]  = cyc;
                log_n++;
            end
            if (init_done && !p_done) done_cyc = cyc;
            if (mem_cke && !p_cke) cke_rise = cyc;
            if (engine_grant && !p_grant) grant_rise = cyc;
            p_done = init_done; p_cke = mem_cke; p_grant = engine_grant;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input int idx, input logic [31:0] d, output int wc);
        cfg_wdata = d;
        cfg_we = 2'(1 << idx);
        step(1);
        wc = cyc;
        cfg_we = 0;
    endtask

    task automatic rd_cfg(input logic [2:0] sel, output logic [31:0] v);
        cfg_re = sel;
        step(1);
        cfg_re = 0;
        v = cfg_rdata;
    endtask

    task automatic pulse_tick();
        ref_tick = 1; step(1); ref_tick = 0; step(1);
    endtask

    // R12: pin values held during reset.
    task automatic t_reset_state();
        check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == C_NOP, "R12 nop", 
              int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), int'(C_NOP));
        check(mem_cke == 1, "R12 cke", mem_cke, 1);
        check(engine_grant == 0 && init_done == 0, "R12 grant/done",
              engine_grant + init_done, 0);
        check(cfg_rdata == 0, "R12 rdata", int'(cfg_rdata), 0);
    endtask

    // R1 and R10: stay quiet before the start write; a tick here is dropped.
    task automatic t_idle();
        log_n = 0;
        pulse_tick();
        step(40);
        check(log_n == 0, "R1 no command before start", log_n, 0);
        check(init_done == 0, "R1 not done", init_done, 0);
    endtask

    // R2, R3, R4, R5, R10: full power-up sequence.
    task automatic t_init(input bit ref8);
        int wc, nref, bad, last, nr;
        log_n = 0;
        wr_cfg(0, {30'b0, 1'b0, ref8}, wc);
        for (int i = 0; i < W + 200 && !init_done; i++) step(1);
        step(20);
        nref = ref8 ? 8 : 2;
        last = nref + 1;
        check(log_n == nref + 2, "R3 command count", log_n, nref + 2);
        nr = 0;
        for (int i = 0; i < log_n; i++) if (log_cmd[i] == C_REF) nr++;
        check(nr == nref, "R3 refresh count", nr, nref);
        check(log_cmd[0] == C_PRE, "R4 precharge code", int'(log_cmd[0]), int'(C_PRE));
        check(log_cyc[0] - wc == W + 1, "R2 wait length", log_cyc[0] - wc, W + 1);
        check(log_addr[0][10] == 1, "R2 addr10", int'(log_addr[0][10]), 1);
        bad = 0;
        if (log_n == nref + 2) begin
            if (log_cyc[1] - log_cyc[0] != TRP + 1) bad++;
            for (int i = 2; i <= last; i++)
                if (log_cyc[i] - log_cyc[i-1] != TRFC + 1) bad++;
            check(log_cmd[last] == C_LMR, "R4 mode code", int'(log_cmd[last]), int'(C_LMR));
            check(log_addr[last] == 12'(MODEW), "R2 mode word", int'(log_addr[last]), MODEW);
            check(done_cyc - log_cyc[last] == TMRD + 1, "R5 done delay",
                  done_cyc - log_cyc[last], TMRD + 1);
        end else bad++;
        check(bad == 0, "R2 spacing", bad, 0);
        check(engine_grant == 1, "R10 grant with no stray refresh", engine_grant, 1);
    endtask

    // R11: registered one-hot readback.
    task automatic t_readback();
        int wc;
        logic [31:0] v;
        wr_cfg(1, 32'hA5A5_1234, wc);
        rd_cfg(3'b001, v); check(v == 32'h1, "R11 reg0", int'(v), 1);
        rd_cfg(3'b010, v); check(v == 32'hA5A5_1234, "R11 reg1", int'(v), int'(32'hA5A5_1234));
        rd_cfg(3'b100, v); check(v == 0, "R11 reg2", int'(v), 0);
        rd_cfg(3'b011, v); check(v == 0, "R11 not one-hot", int'(v), 0);
    endtask

    // R1: a later register 0 write does not restart.
    task automatic t_no_restart();
        int wc;
        log_n = 0;
        wr_cfg(0, 32'h0, wc);
        step(W + 20);
        check(log_n == 0, "R1 no restart", log_n, 0);
        check(init_done == 1, "R1 done kept", init_done, 1);
    endtask

    // R6: entry waits for the engine.
    task automatic t_pd_busy();
        int wc;
        engine_busy = 1;
        wr_cfg(0, 32'h2, wc);
        step(20);
        check(mem_cke == 1, "R6 cke held while busy", mem_cke, 1);
        check(engine_grant == 0, "R6 grant withdrawn", engine_grant, 0);
        engine_busy = 0;
        step(6);
        check(mem_cke == 0, "R6 cke low after idle", mem_cke, 0);
    endtask

    // R7: exit delay with no backlog.
    task automatic t_pd_exit();
        int wc;
        wr_cfg(0, 32'h0, wc);
        step(TXP + 10);
        check(cke_rise - wc == 2, "R7 cke rise", cke_rise - wc, 2);
        check(grant_rise - cke_rise == TXP, "R7 exit delay", grant_rise - cke_rise, TXP);
    endtask

    // R8: ticks during sleep are serviced after wake-up, before the grant.
    task automatic t_pd_pending();
        int wc, nr, bad;
        wr_cfg(0, 32'h2, wc);
        step(8);
        check(mem_cke == 0, "R8 asleep", mem_cke, 0);
        log_n = 0;
        pulse_tick();
        pulse_tick();
        step(10);
        check(log_n == 0, "R8 no command while asleep", log_n, 0);
        wr_cfg(0, 32'h0, wc);
        step(40);
        nr = 0; bad = 0;
        for (int i = 0; i < log_n; i++) begin
            if (log_cmd[i] == C_REF) nr++;
            if (log_cyc[i] <= cke_rise || log_cyc[i] >= grant_rise) bad++;
        end
        check(nr == 2 && log_n == 2, "R8 backlog refreshes", nr, 2);
        check(bad == 0 && grant_rise > wc, "R8 refresh before grant", bad, 0);
    endtask

    // R9: tick in normal operation.
    task automatic t_run_refresh();
        log_n = 0;
        engine_busy = 1;
        pulse_tick();
        step(6);
        check(engine_grant == 0 && log_n == 0, "R9 wait for engine",
              engine_grant + log_n, 0);
        engine_busy = 0;
        step(TRFC + 8);
        check(log_n == 1 && log_cmd[0] == C_REF, "R9 one refresh", log_n, 1);
        check(engine_grant == 1, "R9 grant restored", engine_grant, 1);
    endtask

    initial begin
        step(3);
        t_reset_state();
        rst_n = 1;
        step(2);
        t_idle();
        t_init(1'b1);
        t_readback();
        t_no_restart();
        t_pd_busy();
        t_pd_exit();
        t_pd_pending();
        t_run_refresh();
        rst_n = 0;
        step(2);
        check(init_done == 0, "R5 reset clears done", init_done, 0);
        check(mem_cke == 1, "R12 cke in reset", mem_cke, 1);
        rst_n = 1;
        step(2);
        t_init(1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule